// File: doc/BRIEF.md
# Three-Phase Gate Deadtime Interlock

This block sits between six gate commands (one high-side and one low-side command for each of three bridge phases) and the six matching gate drive outputs. A rising command edge does not reach its output at once. The output turns on only after a programmable deadtime, counted in clock cycles. A falling command turns its output off with no delay. When both commands of one phase are active together, the block keeps both outputs of that phase off and records the event in a sticky status bit. An active-high fault input overrides everything and turns all six outputs off in the same cycle.

A small register port sets the block up. It is meant to be driven by a serial slave interface elsewhere on the chip. Through this port software loads the deadtime code, reads the deadtime, the mode and the status back, and commits the operating mode. The mode has two bits. The full-on bit allows both switches of a phase to conduct at once and removes the deadtime. The zero-deadtime bit removes only the deadtime and keeps the interlock. The mode is accepted only directly after a two-write key sequence, and it can be committed only once between resets. At a 20 MHz clock, one deadtime step is 50 ns, so the code range 0 to 240 spans 0 to 12 µs.

Top module: `gate_interlock_3ph`

## Requirements
- R1: A write to address 0x1 loads the deadtime code. A value above 240 is stored as 240. Reading address 0x1 returns the stored code.
- R2: With deadtime code N in effect, a rising command is first sampled high at clock edge k. Its output then rises just after clock edge k+N. With N=0 it rises just after edge k.
- R3: An output is never high while its command is low, so a falling command turns the output off in the same cycle. A command that drops before its deadtime expires produces no output pulse.
- R4: While the full-on bit is clear and both commands of a phase are high, both outputs of that phase are low in that same cycle. Status bit p (address 0x4, bit p = phase p) is set. An output that was blocked in this way stays low until its command has a new rising edge.
- R5: Reading address 0x4 clears the sticky status bits on that clock edge. A new conflict on the same edge wins over the clear.
- R6: A mode write to address 0x3 (bit 0 full-on, bit 1 zero-deadtime) is applied only when it directly follows the writes 0xA5 and then 0x5A to address 0x2. Any other write in between restarts the sequence.
- R7: Once a mode write has been applied, mode bit 7 reads 1 (locked), and all later mode writes are ignored until reset.
- R8: With full-on or zero-deadtime set, the deadtime is zero. Full-on also lets both outputs of a phase be high together, and in that case no status bit is set.
- R9: While the fault input is high, all six outputs are low in the same cycle. Any on or pending state is discarded, so an output needs a new rising command edge after the fault is gone.
- R10: After reset all outputs are low, the deadtime code is 20, the mode reads 0x00 (unlocked) and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (one deadtime step per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_hi | input | 3 | High-side gate commands, one bit per phase |
| cmd_lo | input | 3 | Low-side gate commands, one bit per phase |
| fault_off | input | 1 | Active-high fault shutdown of all outputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (clears status when reading 0x4) |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| gate_hi | output | 3 | High-side gate drive outputs |
| gate_lo | output | 3 | High-side gate drive outputs' low-side partners, one bit per phase |

## Verification
The assertions sample the commands and the fault input only at the rising clock edge. They assume that these inputs change once per cycle, away from that edge, and that a read or write strobe lasts exactly one cycle. The bench drives every input on the falling edge and holds each strobe for one cycle. It measures turn-on delay by counting rising edges from the cycle in which the command was raised. The turn-off and fault checks look at the outputs a moment after the input changes, in the same low clock phase, before any edge occurs. Each mode-related case first passes through the full key sequence, or deliberately breaks it.

// File: rtl/gil_pkg.sv
// Shared constants and types for the three-phase gate interlock.
// Assumes an 8-bit register data path and a 4-bit register address.
package gil_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_DEAD = 4'h1;
    localparam logic [ADDR_W-1:0] A_KEY  = 4'h2;
    localparam logic [ADDR_W-1:0] A_MODE = 4'h3;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h4;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h5A;

    typedef enum logic [1:0] {
        UNL_IDLE,
        UNL_HALF,
        UNL_OPEN
    } unl_state_t;

    typedef struct packed {
        logic zero_dt;
        logic full_on;
    } mode_t;
endpackage

// File: rtl/gil_cfg.sv
// Configuration registers: deadtime code, one-time-lockable mode and
// sticky shoot-through status, plus the key sequence that guards the mode.
// Assumes wr_en and rd_en are single-cycle strobes from a serial slave.
module gil_cfg
    import gil_pkg::*;
#(
    parameter int PHASES   = 3,
    parameter int DT_W     = 8,
    parameter int DT_MAX   = 240,
    parameter int DT_RESET = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [PHASES-1:0] shoot_evt,
    output logic [DATA_W-1:0] rd_data,
    output logic [DT_W-1:0]   dead_code,
    output mode_t             mode,
    output logic              locked,
    output logic [PHASES-1:0] status
);
    unl_state_t        st_q, st_d;
    logic              key1_hit, key2_hit, mode_commit, stat_clr;
    logic [DATA_W-1:0] sat_val;

    assign key1_hit    = wr_en && (wr_addr == A_KEY) && (wr_data == KEY_FIRST);
    assign key2_hit    = wr_en && (wr_addr == A_KEY) && (wr_data == KEY_SECOND);
    assign mode_commit = wr_en && (wr_addr == A_MODE) && (st_q == UNL_OPEN) && !locked;
    assign stat_clr    = rd_en && (rd_addr == A_STAT);
    assign sat_val     = (wr_data > DATA_W'(DT_MAX)) ? DATA_W'(DT_MAX) : wr_data;

    // Next state of the key sequence; any non-matching write restarts it.
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (st_q == UNL_HALF && key2_hit) st_d = UNL_OPEN;
            else if (key1_hit)                st_d = UNL_HALF;
            else                              st_d = UNL_IDLE;
        end
    end

    // Key sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= UNL_IDLE;
        else        st_q <= st_d;
    end

    // Deadtime code register with saturation on write.
    always_ff @(posedge clk) begin
        if (!rst_n)                               dead_code <= DT_W'(DT_RESET);
        else if (wr_en && wr_addr == A_DEAD)      dead_code <= DT_W'(sat_val);
    end

    // Mode register, committed once per reset through the key sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= '0;
            locked <= 1'b0;
        end else if (mode_commit) begin
            mode.full_on <= wr_data[0];
            mode.zero_dt <= wr_data[1];
            locked       <= 1'b1;
        end
    end

    // Sticky shoot-through status; a new event wins over a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~{PHASES{stat_clr}}) | shoot_evt;
    end

    // Read-back multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DEAD: rd_data = DATA_W'(dead_code);
            A_MODE: begin
                rd_data[DATA_W-1] = locked;
                rd_data[1]        = mode.zero_dt;
                rd_data[0]        = mode.full_on;
            end
            A_STAT: rd_data = DATA_W'(status);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gil_chan.sv
// One gate channel: edge-triggered turn-on after a loaded deadtime count,
// immediate turn-off on command drop or block. Assumes dt_load is stable
// on the edge cycle; later changes do not affect a running count.
module gil_chan #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd,
    input  logic            block,
    input  logic [DT_W-1:0] dt_load,
    output logic            drive
);
    logic            prev_q, on_q, pend_q;
    logic [DT_W-1:0] cnt_q;

    // Edge detection, deadtime countdown and on-state tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            on_q   <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= cmd;
            if (!cmd || block) begin
                on_q   <= 1'b0;
                pend_q <= 1'b0;
            end else if (!prev_q) begin
                if (dt_load == '0) begin
                    on_q <= 1'b1;
                end else begin
                    pend_q <= 1'b1;
                    cnt_q  <= dt_load;
                end
            end else if (pend_q) begin
                if (cnt_q == DT_W'(1)) begin
                    on_q   <= 1'b1;
                    pend_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign drive = on_q && cmd && !block;
endmodule

// File: rtl/gil_leg.sv
// One bridge phase: conflict detection between the two commands and two
// gate channels. Assumes fault is already synchronous to clk.
module gil_leg #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_h,
    input  logic            cmd_l,
    input  logic            full_on,
    input  logic            fault,
    input  logic [DT_W-1:0] dt_eff,
    output logic            drv_h,
    output logic            drv_l,
    output logic            shoot
);
    logic block;

    assign shoot = cmd_h && cmd_l && !full_on;
    assign block = shoot || fault;

    gil_chan #(.DT_W(DT_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_h), .block(block),
        .dt_load(dt_eff), .drive(drv_h)
    );

    gil_chan #(.DT_W(DT_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_l), .block(block),
        .dt_load(dt_eff), .drive(drv_l)
    );
endmodule

// File: rtl/gate_interlock_3ph.sv
// Top of the three-phase deadtime interlock: configuration registers and
// one leg per phase. Assumes commands and fault are synchronous to clk.
module gate_interlock_3ph
    import gil_pkg::*;
#(
    parameter int PHASES   = 3,
    parameter int DT_W     = 8,
    parameter int DT_MAX   = 240,
    parameter int DT_RESET = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] cmd_hi,
    input  logic [PHASES-1:0] cmd_lo,
    input  logic              fault_off,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo
);
    mode_t             mode_w;
    logic              locked_w;
    logic [DT_W-1:0]   dead_w, dt_eff;
    logic [PHASES-1:0] shoot_w, status_w;

    gil_cfg #(
        .PHASES(PHASES), .DT_W(DT_W), .DT_MAX(DT_MAX), .DT_RESET(DT_RESET)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .shoot_evt(shoot_w), .rd_data(rd_data),
        .dead_code(dead_w), .mode(mode_w), .locked(locked_w), .status(status_w)
    );

    assign dt_eff = (mode_w.full_on || mode_w.zero_dt) ? '0 : dead_w;

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        gil_leg #(.DT_W(DT_W)) u_leg (
            .clk(clk), .rst_n(rst_n),
            .cmd_h(cmd_hi[p]), .cmd_l(cmd_lo[p]),
            .full_on(mode_w.full_on), .fault(fault_off), .dt_eff(dt_eff),
            .drv_h(gate_hi[p]), .drv_l(gate_lo[p]), .shoot(shoot_w[p])
        );
    end
endmodule

// File: rtl/gil_checker.sv
// Property checker for gate_interlock_3ph, attached by bind below.
// Assumes inputs change away from the rising clock edge.
module gil_checker #(
    parameter int PHASES = 3,
    parameter int DT_W   = 8,
    parameter int DT_MAX = 240
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHASES-1:0] cmd_hi,
    input logic [PHASES-1:0] cmd_lo,
    input logic              fault_off,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo,
    input logic              full_on,
    input logic              locked,
    input logic [DT_W-1:0]   dead_code,
    input logic [PHASES-1:0] status
);
    AST_DEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dead_code <= DT_W'(DT_MAX)); // R1

    AST_RISE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi[0]) |-> $past(cmd_hi[0])); // R2

    AST_OFF_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi & ~cmd_hi) | (gate_lo & ~cmd_lo)) == '0); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !full_on |-> ((gate_hi & gate_lo) == '0)); // R4

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (((cmd_hi & cmd_lo) != '0) && !full_on)
        |=> ((status & $past(cmd_hi & cmd_lo)) == $past(cmd_hi & cmd_lo))); // R4

    AST_MODE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(full_on) |-> $rose(locked)); // R6

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(full_on))); // R7

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_off |-> (gate_hi == '0 && gate_lo == '0)); // R9
endmodule

bind gate_interlock_3ph gil_checker #(
    .PHASES(PHASES), .DT_W(DT_W), .DT_MAX(DT_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .fault_off(fault_off), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .full_on(mode_w.full_on), .locked(locked_w), .dead_code(dead_w),
    .status(status_w)
);

// File: tb/tb_gate_interlock_3ph.sv
module tb_gate_interlock_3ph;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_hi = '0, cmd_lo = '0;
    logic       fault_off = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] gate_hi, gate_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {written code, expected stored code}
    localparam logic [15:0] DT_VEC [0:6] = '{
        {8'd0,   8'd0},   {8'd1,   8'd1},   {8'd5,   8'd5},   {8'd17,  8'd17},
        {8'd240, 8'd240}, {8'd241, 8'd240}, {8'd255, 8'd240}
    };

    gate_interlock_3ph dut (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .fault_off(fault_off), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock_mode(input logic [7:0] m);
        wr(4'h2, 8'hA5); wr(4'h2, 8'h5A); wr(4'h3, m);
    endtask

    // Count rising edges until the selected output is seen high.
    task automatic measure(input int ph, input bit lo, output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (lo ? gate_lo[ph] : gate_hi[ph]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        chk("R10 gates", {gate_hi, gate_lo}, 0);
        rd(4'h1, d); chk("R10 deadtime", d, 20);
        rd(4'h3, d); chk("R10 mode", d, 0);
        rd(4'h4, d); chk("R10 status", d, 0);

        // R1/R2/R3 table walk over deadtime codes
        for (int i = 0; i < 7; i++) begin
            wr(4'h1, DT_VEC[i][15:8]);
            rd(4'h1, d); chk("R1 readback", d, DT_VEC[i][7:0]);
            cmd_hi[0] = 1'b1;
            measure(0, 1'b0, n); chk("R2 delay", n, DT_VEC[i][7:0] + 1);
            cmd_hi[0] = 1'b0;
            #1 chk("R3 immediate off", gate_hi[0], 0);
            @(negedge clk);
        end

        // R3 cancel before expiry
        wr(4'h1, 8'd10);
        cmd_lo[1] = 1'b1;
        repeat (5) @(negedge clk);
        cmd_lo[1] = 1'b0;
        n = 0;
        repeat (15) begin @(negedge clk); n += gate_lo[1]; end
        chk("R3 cancelled pulse", n, 0);

        // R4 conflict and R5 status clear
        wr(4'h1, 8'd2);
        cmd_hi[2] = 1'b1;
        measure(2, 1'b0, n); chk("R2 delay dt2", n, 3);
        cmd_lo[2] = 1'b1;
        #1 chk("R4 both low", {gate_hi[2], gate_lo[2]}, 0);
        @(negedge clk);
        cmd_lo[2] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 needs fresh edge", gate_hi[2], 0);
        cmd_hi[2] = 1'b0;
        rd(4'h4, d); chk("R4 sticky bit", d, 8'h04);
        rd(4'h4, d); chk("R5 cleared by read", d, 0);

        // R6 mode guarded by key sequence
        wr(4'h3, 8'h01);
        rd(4'h3, d); chk("R6 no key", d, 0);
        wr(4'h2, 8'hA5); wr(4'h2, 8'h5A); wr(4'h1, 8'd50); wr(4'h3, 8'h01);
        rd(4'h3, d); chk("R6 write between", d, 0);
        wr(4'h2, 8'hA5); wr(4'h2, 8'h33); wr(4'h2, 8'h5A); wr(4'h3, 8'h01);
        rd(4'h3, d); chk("R6 wrong key", d, 0);
        unlock_mode(8'h01);
        rd(4'h3, d); chk("R6 R7 committed", d, 8'h81);

        // R8 full-on: both on, no deadtime, no status
        cmd_hi[0] = 1'b1; cmd_lo[0] = 1'b1;
        measure(0, 1'b0, n); chk("R8 no deadtime", n, 1);
        chk("R8 low side on too", gate_lo[0], 1);
        rd(4'h4, d); chk("R8 no status", d, 0);

        // R7 second commit ignored
        unlock_mode(8'h00);
        rd(4'h3, d); chk("R7 lock holds", d, 8'h81);
        chk("R7 outputs unchanged", {gate_hi[0], gate_lo[0]}, 3);

        // R9 fault shutdown
        fault_off = 1'b1;
        #1 chk("R9 same cycle", {gate_hi, gate_lo}, 0);
        @(negedge clk); fault_off = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 stays off", {gate_hi, gate_lo}, 0);
        cmd_hi[0] = 1'b0; cmd_lo[0] = 1'b0;
        @(negedge clk);

        // R10 reset releases the lock
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(4'h3, d); chk("R10 mode after reset", d, 0);
        rd(4'h1, d); chk("R10 deadtime after reset", d, 20);

        // R8 zero-deadtime keeps the interlock
        unlock_mode(8'h02);
        rd(4'h3, d); chk("R8 zero-dt mode", d, 8'h82);
        wr(4'h1, 8'd100);
        cmd_hi[1] = 1'b1;
        measure(1, 1'b0, n); chk("R8 zero-dt delay", n, 1);
        cmd_lo[1] = 1'b1;
        #1 chk("R4 interlock in zero-dt", {gate_hi[1], gate_lo[1]}, 0);
        @(negedge clk);
        cmd_hi[1] = 1'b0; cmd_lo[1] = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule